// File: doc/BRIEF.md
# Programmable Clock Divider With Lock

This block derives a divided clock from a reference clock under the control of one 32-bit register. Software writes the register in a single cycle. Each write sets the output enable and the reference-buffer gate, and stores a divide ratio in a staging field. A write can also request a reset pulse for a downstream domain, and it can carry an update strobe. The counter only takes the staged ratio when the strobe is set. After that, a lock flag reports that the new ratio has settled.

The divided clock is a registered square wave. With it comes a one-cycle enable pulse that marks the start of each output period, for logic that runs on the reference clock. A ratio of zero behaves as divide-by-one. Ratio requests that are too large for the field are clamped. A build option can leave out ratios 1 to 3: in that case a request for 1 or 2 becomes bypass (0), and a request for 3 becomes 4. A second option moves the lock flag to another bit.

The configuration port is a plain register port. It moves no data stream, so it has no valid/ready handshake. A write is accepted in the cycle `cfg_wr_en` is high and can never be refused. Read data is combinational from the stored state.

Top module: `clkdiv_lock`

## Requirements
- R1: After reset, the register reads 0x8000_0000 (0x0800_0000 with LOCK_ALT=1): disabled, ratio 0, locked. `div_clk_o`, `div_ce_o` and `dom_rst_o` are low, and `ref_buf_en_o` is high.
- R2: Register layout:
  - bit 0: enable
  - bit 1: reset request (reads 1 while the pulse runs)
  - bit 2: update strobe (reads 1 while a load is pending)
  - bits 4 upward, DIV_W bits: staged ratio
  - bit 28: buffer gate
  - bit 31 (bit 27 with LOCK_ALT=1): read-only lock flag
  - all other bits read 0.
- R3: With N = ratio (1 when the ratio is 0), `div_ce_o` pulses once every N cycles. In each period `div_clk_o` is high for floor(N/2) cycles and low for the rest, so an odd N gives a high time one cycle shorter than the low time. `div_ce_o` is only high while `div_clk_o` is low.
- R4: A ratio written without the strobe is only staged. The output period does not change.
- R5: A strobe write clears the lock flag in the next cycle, and bit 2 reads 1. The new ratio is loaded at the next cycle with the output low (at once when disabled, or at the end of the current period at the latest). After the load, bit 2 reads 0.
- R6: Lock rises only at the end of a settle window of 2N cycles after the load. With the output disabled, lock is set no more than 4N cycles after the strobe write.
- R7: The ratio request is bits 26:4 of the write data. A request above 2^DIV_W-1 is stored as 2^DIV_W-1.
- R8: With NO_LOW_RATIO=1, requests of 1 or 2 are stored as 0 and a request of 3 is stored as 4. Other values are stored unchanged.
- R9: While enable is low, `div_clk_o` and `div_ce_o` stay low from the cycle after enable is seen low.
- R10: Writing bit 1 drives `dom_rst_o` high for exactly RST_LEN (8) cycles from the cycle after the write. Bit 1 then clears itself.
- R11: `ref_buf_en_o` is the inverse of bit 28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_data | output | 32 | Register read data |
| div_clk_o | output | 1 | Divided clock |
| div_ce_o | output | 1 | One-cycle pulse at the start of each output period |
| ref_buf_en_o | output | 1 | Reference buffer pass enable |
| dom_rst_o | output | 1 | Downstream domain reset pulse |

## Verification
The assertions check the cycle-level rules on every cycle:
- the outputs fall silent after enable drops;
- the period pulse never coincides with a high output;
- a strobe or a load clears lock, and lock rises only at the end of a settle window;
- the pending flag clears after a load;
- clamping and remapping hold in the stored ratio;
- the reset pulse starts and ends when it should.

Only the bench scenarios can show the arithmetic:
- the measured period and high time for every ratio of a 4-bit field;
- the lock latency against the 4N bound;
- that a staged ratio leaves the period alone until the strobe;
- the exact length of the reset pulse.

// File: rtl/clkdiv_lock_pkg.sv
package clkdiv_lock_pkg;
  localparam int EN_BIT   = 0;
  localparam int RQR_BIT  = 1;
  localparam int UPD_BIT  = 2;
  localparam int RAT_LSB  = 4;
  localparam int REQ_MSB  = 26;
  localparam int REQ_W    = REQ_MSB - RAT_LSB + 1;
  localparam int GATE_BIT = 28;

  function automatic int lock_pos(input bit alt);
    return alt ? 27 : 31;
  endfunction
endpackage

// File: rtl/clkdiv_lock_regs.sv
module clkdiv_lock_regs
  import clkdiv_lock_pkg::*;
#(
  parameter int DIV_W        = 6,
  parameter bit LOCK_ALT     = 1'b0,
  parameter bit NO_LOW_RATIO = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             pend,
  input  logic             rst_busy,
  input  logic             lock,
  output logic             en,
  output logic             gate,
  output logic [DIV_W-1:0] ratio_stage,
  output logic             upd_wr,
  output logic             rqr_wr,
  output logic [31:0]      rd_data
);
  localparam int LPOS = lock_pos(LOCK_ALT);
  localparam logic [REQ_W-1:0] REQ_MAX = REQ_W'((64'd1 << DIV_W) - 64'd1);
  localparam logic [DIV_W-1:0] RAT_MAX = DIV_W'((64'd1 << DIV_W) - 64'd1);

  logic [REQ_W-1:0] req;
  logic [DIV_W-1:0] clamped;
  logic [DIV_W-1:0] mapped;
  logic             unused_bits;

  assign req         = wr_data[REQ_MSB:RAT_LSB];
  assign unused_bits = ^{wr_data[31:29], wr_data[27], wr_data[3]};
  assign clamped     = (req > REQ_MAX) ? RAT_MAX : req[DIV_W-1:0];
  assign upd_wr      = wr_en && wr_data[UPD_BIT];
  assign rqr_wr      = wr_en && wr_data[RQR_BIT];

  generate
    if (NO_LOW_RATIO) begin : g_skip_low
      always_comb begin
        if (clamped == DIV_W'(1) || clamped == DIV_W'(2)) mapped = '0;
        else if (clamped == DIV_W'(3))                    mapped = DIV_W'(4);
        else                                              mapped = clamped;
      end
      AST_NO_LOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_stage == '0 || ratio_stage >= DIV_W'(4)));  // R8
    end else begin : g_full
      assign mapped = clamped;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en          <= 1'b0;
      gate        <= 1'b0;
      ratio_stage <= '0;
    end else if (wr_en) begin
      en          <= wr_data[EN_BIT];
      gate        <= wr_data[GATE_BIT];
      ratio_stage <= mapped;
    end
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[EN_BIT]                = en;
    rd_data[RQR_BIT]               = rst_busy;
    rd_data[UPD_BIT]               = pend;
    rd_data[RAT_LSB +: DIV_W]      = ratio_stage;
    rd_data[GATE_BIT]              = gate;
    rd_data[LPOS]                  = lock;
  end

  AST_CLAMP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req > REQ_MAX && !NO_LOW_RATIO) |=> (ratio_stage == RAT_MAX));  // R7
endmodule

// File: rtl/clkdiv_lock_counter.sv
module clkdiv_lock_counter #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             upd_wr,
  input  logic [DIV_W-1:0] ratio_stage,
  output logic             pend,
  output logic             load,
  output logic [DIV_W-1:0] n_act,
  output logic             clk_q,
  output logic             ce_q
);
  logic [DIV_W-1:0] ratio_act;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W-1:0] n_low;
  logic             at_end;

  assign n_act   = (ratio_act == '0) ? DIV_W'(1) : ratio_act;
  assign n_low   = n_act - (n_act >> 1);
  assign at_end  = (cnt == n_act - DIV_W'(1));
  assign cnt_nxt = at_end ? '0 : cnt + DIV_W'(1);
  assign load    = pend && (!en || !clk_q || at_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      ratio_act <= '0;
      cnt       <= '0;
      clk_q     <= 1'b0;
      ce_q      <= 1'b0;
    end else begin
      if (upd_wr)    pend <= 1'b1;
      else if (load) pend <= 1'b0;

      if (load) begin
        ratio_act <= ratio_stage;
        cnt       <= '0;
        clk_q     <= 1'b0;
        ce_q      <= en;
      end else if (!en) begin
        cnt   <= '0;
        clk_q <= 1'b0;
        ce_q  <= 1'b0;
      end else begin
        cnt   <= cnt_nxt;
        clk_q <= (cnt_nxt >= n_low);
        ce_q  <= (cnt_nxt == '0);
      end
    end
  end

  AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!clk_q && !ce_q));  // R9
  AST_CE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q |-> !clk_q);  // R3
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !upd_wr) |=> !pend);  // R5
endmodule

// File: rtl/clkdiv_lock_lockmon.sv
module clkdiv_lock_lockmon #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_wr,
  input  logic             load,
  input  logic [DIV_W-1:0] n_act,
  output logic             lock
);
  localparam int LW = DIV_W + 1;

  logic [LW-1:0] wait_cnt;
  logic [LW-1:0] settle_last;
  logic          run;

  assign settle_last = {n_act, 1'b0} - LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock     <= 1'b1;
      run      <= 1'b0;
      wait_cnt <= '0;
    end else if (upd_wr) begin
      lock <= 1'b0;
      run  <= 1'b0;
    end else if (load) begin
      lock     <= 1'b0;
      run      <= 1'b1;
      wait_cnt <= '0;
    end else if (run) begin
      if (wait_cnt == settle_last) begin
        lock <= 1'b1;
        run  <= 1'b0;
      end else begin
        wait_cnt <= wait_cnt + LW'(1);
      end
    end
  end

  AST_STROBE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_wr |=> !lock);  // R5
  AST_LOAD_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !lock);  // R5
  AST_LOCK_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(run));  // R6
endmodule

// File: rtl/clkdiv_lock_rstpulse.sv
module clkdiv_lock_rstpulse #(
  parameter int RST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rqr_wr,
  output logic busy
);
  localparam int RW = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
  localparam logic [RW-1:0] LAST = RW'(RST_LEN - 1);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (rqr_wr) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == LAST) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + RW'(1);
    end
  end

  AST_RST_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rqr_wr && !busy) |=> busy);  // R10
  AST_RST_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == LAST) |=> !busy);  // R10
endmodule

// File: rtl/clkdiv_lock.sv
module clkdiv_lock #(
  parameter int DIV_W        = 6,
  parameter bit LOCK_ALT     = 1'b0,
  parameter bit NO_LOW_RATIO = 1'b0,
  parameter int RST_LEN      = 8
) (
  input  logic        clk_ref,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] cfg_rd_data,
  output logic        div_clk_o,
  output logic        div_ce_o,
  output logic        ref_buf_en_o,
  output logic        dom_rst_o
);
  logic             en;
  logic             gate;
  logic [DIV_W-1:0] ratio_stage;
  logic             upd_wr;
  logic             rqr_wr;
  logic             pend;
  logic             load;
  logic [DIV_W-1:0] n_act;
  logic             lock;

  clkdiv_lock_regs #(
    .DIV_W(DIV_W), .LOCK_ALT(LOCK_ALT), .NO_LOW_RATIO(NO_LOW_RATIO)
  ) u_regs (
    .clk(clk_ref), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .pend(pend), .rst_busy(dom_rst_o), .lock(lock), .en(en), .gate(gate),
    .ratio_stage(ratio_stage), .upd_wr(upd_wr), .rqr_wr(rqr_wr),
    .rd_data(cfg_rd_data)
  );

  clkdiv_lock_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk_ref), .rst_n(rst_n), .en(en), .upd_wr(upd_wr),
    .ratio_stage(ratio_stage), .pend(pend), .load(load), .n_act(n_act),
    .clk_q(div_clk_o), .ce_q(div_ce_o)
  );

  clkdiv_lock_lockmon #(.DIV_W(DIV_W)) u_lock (
    .clk(clk_ref), .rst_n(rst_n), .upd_wr(upd_wr), .load(load),
    .n_act(n_act), .lock(lock)
  );

  clkdiv_lock_rstpulse #(.RST_LEN(RST_LEN)) u_rstp (
    .clk(clk_ref), .rst_n(rst_n), .rqr_wr(rqr_wr), .busy(dom_rst_o)
  );

  assign ref_buf_en_o = !gate;
endmodule

// File: tb/clkdiv_lock_test.sv
`timescale 1ns/1ps
module clkdiv_lock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd, rd_alt;
  logic        dclk, dce, bufen, drst;
  logic        dclk_a, dce_a, bufen_a, drst_a;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  clkdiv_lock #(.DIV_W(4), .LOCK_ALT(1'b0), .NO_LOW_RATIO(1'b0)) uut (
    .clk_ref(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_data(wr_data),
    .cfg_rd_data(rd), .div_clk_o(dclk), .div_ce_o(dce),
    .ref_buf_en_o(bufen), .dom_rst_o(drst)
  );

  clkdiv_lock #(.DIV_W(4), .LOCK_ALT(1'b1), .NO_LOW_RATIO(1'b1)) uut_alt (
    .clk_ref(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_data(wr_data),
    .cfg_rd_data(rd_alt), .div_clk_o(dclk_a), .div_ce_o(dce_a),
    .ref_buf_en_o(bufen_a), .dom_rst_o(drst_a)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input bit rq, input bit up,
                                     input int req, input bit gate);
    logic [31:0] v;
    v = '0;
    v[0] = en; v[1] = rq; v[2] = up; v[28] = gate;
    v[26:4] = 23'(req);
    return v;
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_lock(output int k);
    k = 0;
    while (!rd[31] && k < 400) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic measure(output int per, output int hi);
    int g;
    g = 0;
    while (!dce && g < 64) begin @(negedge clk); g++; end
    per = 0; hi = 0;
    do begin
      @(negedge clk);
      per++;
      if (dclk) hi++;
    end while (!dce && per < 64);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int k, per, hi, cnt;
    int exp_alt [7] = '{0, 0, 0, 4, 4, 5, 6};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 main read", rd, 32'h8000_0000);
    chk("R1 alt read lock at bit 27", rd_alt, 32'h0800_0000);
    chk("R1 outputs low", {dclk, dce, drst}, 0);
    chk("R1 buffer enabled", bufen, 1);

    // R11 buffer gate
    wr(mk(0, 0, 0, 0, 1));
    chk("R11 gate set", bufen, 0);
    chk("R2 gate bit 28", rd[28], 1);
    wr(mk(0, 0, 0, 0, 0));
    chk("R11 gate clear", bufen, 1);

    // R3 R5 R6 R9 sweep all ratios
    for (int d = 0; d < 16; d++) begin
      int n;
      n = (d == 0) ? 1 : d;
      wr(mk(0, 0, 1, d, 0));
      chk($sformatf("R5 pending bit2 d=%0d", d), rd[2], 1);
      chk($sformatf("R5 lock cleared d=%0d", d), rd[31], 0);
      wait_lock(k);
      chk($sformatf("R6 lock within 4N d=%0d", d), (k > 0 && k <= 4 * n), 1);
      chk($sformatf("R5 bit2 self-clear d=%0d", d), rd[2], 0);
      chk($sformatf("R2 ratio readback d=%0d", d), rd[7:4], d);
      wr(mk(1, 0, 0, d, 0));
      chk($sformatf("R2 enable bit0 d=%0d", d), rd[0], 1);
      measure(per, hi);
      chk($sformatf("R3 period d=%0d", d), per, n);
      chk($sformatf("R3 high time d=%0d", d), hi, n / 2);
      wr(mk(0, 0, 0, d, 0));
      @(negedge clk);
      cnt = 0;
      for (int c = 0; c < 4; c++) begin
        if (dclk || dce) cnt++;
        @(negedge clk);
      end
      chk($sformatf("R9 quiet when disabled d=%0d", d), cnt, 0);
    end

    // R4 staging without strobe, then strobe while running
    wr(mk(0, 0, 1, 5, 0));
    wait_lock(k);
    wr(mk(1, 0, 0, 5, 0));
    measure(per, hi);
    chk("R3 period 5 before staging", per, 5);
    wr(mk(1, 0, 0, 9, 0));
    measure(per, hi);
    chk("R4 staged ratio ignored period", per, 5);
    measure(per, hi);
    chk("R4 staged ratio ignored again", per, 5);
    wr(mk(1, 0, 1, 9, 0));
    chk("R5 lock cleared while running", rd[31], 0);
    wait_lock(k);
    chk("R5 lock after running update", (k > 0 && k <= 5 + 4 * 9), 1);
    chk("R5 bit2 cleared after running update", rd[2], 0);
    measure(per, hi);
    chk("R3 period 9 after strobe", per, 9);
    chk("R3 high time 9 after strobe", hi, 4);

    // R7 clamp
    wr(mk(0, 0, 0, 200, 0));
    chk("R7 clamp 200", rd[7:4], 15);
    wr(mk(0, 0, 0, 16, 0));
    chk("R7 clamp 16", rd[7:4], 15);
    wr(mk(0, 0, 0, 1 << 22, 0));
    chk("R7 clamp top request bit", rd[7:4], 15);
    chk("R7 clamp alt", rd_alt[7:4], 15);
    chk("R2 upper bits zero", rd[26:8], 0);

    // R8 low ratio remap
    for (int r = 0; r < 7; r++) begin
      wr(mk(0, 0, 0, r, 0));
      chk($sformatf("R8 alt remap req=%0d", r), rd_alt[7:4], exp_alt[r]);
      chk($sformatf("R2 main unmapped req=%0d", r), rd[7:4], r);
    end

    // R10 reset pulse
    wr(mk(0, 1, 0, 0, 0));
    chk("R10 bit1 busy", rd[1], 1);
    cnt = 0;
    while (drst && cnt < 40) begin
      cnt++;
      @(negedge clk);
    end
    chk("R10 pulse length", cnt, 8);
    chk("R10 bit1 self-clear", rd[1], 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule